// File: doc/BRIEF.md
# Adaptive Decision Feedback Equalizer

This block cancels post-cursor intersymbol interference on a digitized serial receive stream. It takes one signed sample per unit interval, for example the code from a coarse converter. From each sample it subtracts the interference that the four previous binary decisions left behind, then slices the result to a new decision. The feedback weights and a reference signal level are learned on line with a sign-sign least-mean-squares rule. The rule is driven by the sign of the residual between the equalized value and the reference level, scaled by the decision.

The four feedback taps have different precisions. The first-post-cursor tap is an unsigned 5-bit magnitude. The second is a signed value limited to ±15. The third and fourth are signed values limited to ±7. The reference level is an unsigned 7-bit value. Learning runs only while the adaptation enable is high. While it is low, every weight holds, and a preload strobe can write all the weights and the level at once. The result of a sample appears one register stage after the sample is presented.

Top module: `dfe_adapt_top`

## Requirements
- R1: The equalized value equals the sample minus the sum, over taps i = 1..4, of weight i times decision d(k-i), where a decision counts as +1 or -1. The decision history holds +1 in every slot after reset.
- R2: The decision output dec_o is 1 (meaning +1) when the equalized value is zero or positive, and 0 (meaning -1) when it is negative.
- R3: vld_o, dec_o, eq_o and err_neg_o reflect the sample presented with samp_vld_i one clock edge earlier. vld_o is high exactly in the cycle after a valid sample.
- R4: err_neg_o is 1 when e = eq - L*d is negative, where L is the reference level before that sample's update and d is the new decision. It is 0 when e is zero or positive.
- R5: On a valid sample with adapt_en_i high, each tap i moves by exactly one step. It moves +1 when the sign of e equals the sign of d(k-i) (zero counts as positive), and -1 otherwise.
- R6: On a valid sample with adapt_en_i high, the reference level moves +1 when the sign of e times d is positive, and -1 otherwise.
- R7: Values stop at their limits instead of wrapping. Tap 1 is limited to 0..31, tap 2 to -15..15, taps 3 and 4 to -7..7, and the level to 0..127. Preloaded values are clamped to the same limits.
- R8: With adapt_en_i low, the weights and level hold, except that load_i writes all of them at the next edge. With adapt_en_i high, load_i is ignored. A sample that arrives together with a load is equalized with the old weights.
- R9: A cycle without samp_vld_i changes neither the weights, the level, the decision history, nor the held dec_o/eq_o/err_neg_o values.
- R10: Under adaptation on a channel with a main cursor of 40 and post-cursors 20, 10, -5, 3, the taps settle within ±2 of the post-cursors and the level settles within ±2 of 40.
- R11: After reset, the taps are 0, the level is 32, and the outputs vld_o, dec_o, eq_o and err_neg_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| samp_i | input | 8 | Signed receiver sample |
| samp_vld_i | input | 1 | Sample present this cycle |
| adapt_en_i | input | 1 | Enable sign-sign learning |
| load_i | input | 1 | Preload strobe, honoured only while adapt_en_i is low |
| ld_tap1_i | input | 5 | Preload value for tap 1 (unsigned) |
| ld_tap2_i | input | 5 | Preload value for tap 2 (signed) |
| ld_tap3_i | input | 4 | Preload value for tap 3 (signed) |
| ld_tap4_i | input | 4 | Preload value for tap 4 (signed) |
| ld_dlev_i | input | 7 | Preload value for the reference level |
| dec_o | output | 1 | Decision: 1 = +1, 0 = -1 |
| eq_o | output | 9 | Signed equalized value |
| err_neg_o | output | 1 | Residual sign: 1 = negative |
| vld_o | output | 1 | Outputs refer to a new sample |
| tap1_o | output | 5 | Current tap 1 |
| tap2_o | output | 5 | Current tap 2 (signed) |
| tap3_o | output | 4 | Current tap 3 (signed) |
| tap4_o | output | 4 | Current tap 4 (signed) |
| dlev_o | output | 7 | Current reference level |

## Verification
Two functions can meet in one cycle: equalizing a sample and rewriting the weights. Either can rewrite them, a preload or a learning step. The bench presents a sample in the same cycle as a preload, with adaptation off. The scoreboard then expects the equalized value to come from the old weights, and the following state to hold the clamped preload. It also raises preload and adaptation together with a sample. There the expected weights are the learning step alone, and the preload values must not appear at the tap outputs. Saturation is provoked the same way: a weight sits at its limit while a learning step pushes it outward.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
    // Number of post-cursor feedback taps; each tap has its own precision.
    localparam int DFE_TAPS = 4;
endpackage

// File: rtl/dfe_isi_sum.sv
module dfe_isi_sum #(
    parameter int NT   = 4,
    parameter int WW   = 6,
    parameter int SUMW = 8
) (
    input  logic [NT-1:0][WW-1:0] taps_i,
    input  logic [NT-1:0]         hist_neg_i,
    output logic signed [SUMW-1:0] isi_o
);
    logic signed [SUMW-1:0] term [NT];

    // Each term is +w or -w depending on the past decision's sign.
    for (genvar g = 0; g < NT; g++) begin : g_term
        logic signed [SUMW-1:0] w_ext;
        assign w_ext   = SUMW'($signed(taps_i[g]));
        assign term[g] = hist_neg_i[g] ? -w_ext : w_ext;
    end

    always_comb begin
        isi_o = '0;
        for (int i = 0; i < NT; i++) begin
            isi_o = isi_o + term[i];
        end
    end
endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer #(
    parameter int SW   = 8,
    parameter int ISIW = 8,
    parameter int ZW   = 9,
    parameter int DVW  = 8
) (
    input  logic signed [SW-1:0]   samp_i,
    input  logic signed [ISIW-1:0] isi_i,
    input  logic [DVW-1:0]         dlev_i,
    output logic signed [ZW-1:0]   z_o,
    output logic                   dec_o,
    output logic                   err_neg_o
);
    localparam int EW = ((ZW > DVW) ? ZW : DVW) + 1;

    logic signed [EW-1:0] lvl;
    logic signed [EW-1:0] err;

    always_comb begin
        z_o       = ZW'(samp_i) - ZW'(isi_i);
        dec_o     = ~z_o[ZW-1];
        // Level is non-negative, so its top bit is always clear.
        lvl       = EW'($signed(dlev_i));
        err       = EW'(z_o) - (dec_o ? lvl : -lvl);
        err_neg_o = err[EW-1];
    end
endmodule

// File: rtl/dfe_weight_next.sv
module dfe_weight_next #(
    parameter int W  = 6,
    parameter int LO = 0,
    parameter int HI = 31
) (
    input  logic signed [W-1:0] cur_i,
    input  logic                step_en_i,
    input  logic                up_i,
    input  logic                ld_en_i,
    input  logic signed [W-1:0] ld_val_i,
    output logic signed [W-1:0] nxt_o
);
    localparam logic signed [W-1:0] LO_V = W'(LO);
    localparam logic signed [W-1:0] HI_V = W'(HI);

    always_comb begin
        nxt_o = cur_i;
        if (ld_en_i) begin
            if (ld_val_i < LO_V)      nxt_o = LO_V;
            else if (ld_val_i > HI_V) nxt_o = HI_V;
            else                      nxt_o = ld_val_i;
        end else if (step_en_i) begin
            if (up_i && (cur_i < HI_V))       nxt_o = cur_i + 1'b1;
            else if (!up_i && (cur_i > LO_V)) nxt_o = cur_i - 1'b1;
        end
    end
endmodule

// File: rtl/dfe_adapt_top.sv
module dfe_adapt_top #(
    parameter int SW        = 8,
    parameter int MAG1      = 5,
    parameter int MAG2      = 4,
    parameter int MAG34     = 3,
    parameter int DLW       = 7,
    parameter int DLEV_INIT = 32,
    localparam int T2W  = MAG2 + 1,
    localparam int T34W = MAG34 + 1,
    localparam int WW   = MAG1 + 1,
    localparam int ISIW = WW + 2,
    localparam int ZW   = ((SW > ISIW) ? SW : ISIW) + 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic signed [SW-1:0]   samp_i,
    input  logic                   samp_vld_i,
    input  logic                   adapt_en_i,
    input  logic                   load_i,
    input  logic [MAG1-1:0]        ld_tap1_i,
    input  logic signed [T2W-1:0]  ld_tap2_i,
    input  logic signed [T34W-1:0] ld_tap3_i,
    input  logic signed [T34W-1:0] ld_tap4_i,
    input  logic [DLW-1:0]         ld_dlev_i,
    output logic                   dec_o,
    output logic signed [ZW-1:0]   eq_o,
    output logic                   err_neg_o,
    output logic                   vld_o,
    output logic [MAG1-1:0]        tap1_o,
    output logic signed [T2W-1:0]  tap2_o,
    output logic signed [T34W-1:0] tap3_o,
    output logic signed [T34W-1:0] tap4_o,
    output logic [DLW-1:0]         dlev_o
);
    import dfe_pkg::*;

    localparam int NT  = DFE_TAPS;
    localparam int DVW = DLW + 1;

    typedef struct packed {
        logic                  vld;
        logic                  dec;
        logic                  err_neg;
        logic signed [ZW-1:0]  eq;
        logic [NT-1:0]         hist_neg;
        logic [NT-1:0][WW-1:0] taps;
        logic [DVW-1:0]        dlev;
    } dfe_state_t;

    dfe_state_t s_d, s_q;

    function automatic int tap_hi(int idx);
        case (idx)
            0:       return 2**MAG1 - 1;
            1:       return 2**MAG2 - 1;
            default: return 2**MAG34 - 1;
        endcase
    endfunction

    function automatic int tap_lo(int idx);
        return (idx == 0) ? 0 : -tap_hi(idx);
    endfunction

    // Preload values widened to the common storage width.
    logic [NT-1:0][WW-1:0] ld_vals;
    assign ld_vals[0] = {1'b0, ld_tap1_i};
    assign ld_vals[1] = WW'(ld_tap2_i);
    assign ld_vals[2] = WW'(ld_tap3_i);
    assign ld_vals[3] = WW'(ld_tap4_i);

    logic signed [ISIW-1:0] isi;
    logic signed [ZW-1:0]   z;
    logic                   dec_new;
    logic                   err_new;
    logic                   step_en;
    logic                   ld_en;
    logic [NT-1:0][WW-1:0]  taps_nxt;
    logic signed [DVW-1:0]  dlev_nxt;

    assign step_en = samp_vld_i & adapt_en_i;
    assign ld_en   = load_i & ~adapt_en_i;

    dfe_isi_sum #(.NT(NT), .WW(WW), .SUMW(ISIW)) u_isi (
        .taps_i     (s_q.taps),
        .hist_neg_i (s_q.hist_neg),
        .isi_o      (isi)
    );

    dfe_slicer #(.SW(SW), .ISIW(ISIW), .ZW(ZW), .DVW(DVW)) u_slicer (
        .samp_i    (samp_i),
        .isi_i     (isi),
        .dlev_i    (s_q.dlev),
        .z_o       (z),
        .dec_o     (dec_new),
        .err_neg_o (err_new)
    );

    // Tap i pairs with decision d(k-1-i): step up when error and decision signs agree.
    for (genvar i = 0; i < NT; i++) begin : g_tap
        dfe_weight_next #(.W(WW), .LO(tap_lo(i)), .HI(tap_hi(i))) u_w (
            .cur_i     (s_q.taps[i]),
            .step_en_i (step_en),
            .up_i      (~(err_new ^ s_q.hist_neg[i])),
            .ld_en_i   (ld_en),
            .ld_val_i  (ld_vals[i]),
            .nxt_o     (taps_nxt[i])
        );
    end

    dfe_weight_next #(.W(DVW), .LO(0), .HI(2**DLW - 1)) u_lvl (
        .cur_i     (s_q.dlev),
        .step_en_i (step_en),
        .up_i      (~(err_new ^ ~dec_new)),
        .ld_en_i   (ld_en),
        .ld_val_i  ({1'b0, ld_dlev_i}),
        .nxt_o     (dlev_nxt)
    );

    always_comb begin
        s_d      = s_q;
        s_d.taps = taps_nxt;
        s_d.dlev = dlev_nxt;
        s_d.vld  = samp_vld_i;
        if (samp_vld_i) begin
            s_d.dec      = dec_new;
            s_d.err_neg  = err_new;
            s_d.eq       = z;
            s_d.hist_neg = {s_q.hist_neg[NT-2:0], ~dec_new};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.dlev <= DVW'(DLEV_INIT);
        end else begin
            s_q <= s_d;
        end
    end

    assign vld_o     = s_q.vld;
    assign dec_o     = s_q.dec;
    assign eq_o      = s_q.eq;
    assign err_neg_o = s_q.err_neg;
    assign tap1_o    = s_q.taps[0][MAG1-1:0];
    assign tap2_o    = s_q.taps[1][T2W-1:0];
    assign tap3_o    = s_q.taps[2][T34W-1:0];
    assign tap4_o    = s_q.taps[3][T34W-1:0];
    assign dlev_o    = s_q.dlev[DLW-1:0];
endmodule

// File: rtl/dfe_adapt_chk.sv
module dfe_adapt_chk #(
    parameter int MAG1  = 5,
    parameter int MAG2  = 4,
    parameter int MAG34 = 3,
    parameter int DLW   = 7,
    parameter int ZW    = 9
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     samp_vld_i,
    input logic                     adapt_en_i,
    input logic                     load_i,
    input logic                     dec_o,
    input logic signed [ZW-1:0]     eq_o,
    input logic                     vld_o,
    input logic [MAG1-1:0]          tap1_o,
    input logic signed [MAG2:0]     tap2_o,
    input logic signed [MAG34:0]    tap3_o,
    input logic signed [MAG34:0]    tap4_o,
    input logic [DLW-1:0]           dlev_o
);
    localparam int H2 = 2**MAG2 - 1;
    localparam int H3 = 2**MAG34 - 1;

    assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o == $past(samp_vld_i));

    assert_slice_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |-> (dec_o == (eq_o >= 0)));

    assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(tap2_o) >= -H2) && (int'(tap3_o) >= -H3) && (int'(tap4_o) >= -H3));

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!adapt_en_i && !load_i) |->
            ($stable(tap1_o) && $stable(tap2_o) && $stable(tap3_o) && $stable(tap4_o) && $stable(dlev_o)));

    assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!samp_vld_i && !load_i) |->
            ($stable(tap1_o) && $stable(tap2_o) && $stable(tap3_o) && $stable(tap4_o) && $stable(dlev_o)));

    assert_unit_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(adapt_en_i && samp_vld_i) |->
            ((int'(tap1_o) - int'($past(tap1_o)) <= 1) && (int'(tap1_o) - int'($past(tap1_o)) >= -1)
             && (int'(tap2_o) - int'($past(tap2_o)) <= 1) && (int'(tap2_o) - int'($past(tap2_o)) >= -1)));

    assert_level_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(adapt_en_i && samp_vld_i) |->
            ((int'(dlev_o) - int'($past(dlev_o)) <= 1) && (int'(dlev_o) - int'($past(dlev_o)) >= -1)));
endmodule

bind dfe_adapt_top dfe_adapt_chk #(
    .MAG1(MAG1), .MAG2(MAG2), .MAG34(MAG34), .DLW(DLW), .ZW(ZW)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .samp_vld_i (samp_vld_i),
    .adapt_en_i (adapt_en_i),
    .load_i     (load_i),
    .dec_o      (dec_o),
    .eq_o       (eq_o),
    .vld_o      (vld_o),
    .tap1_o     (tap1_o),
    .tap2_o     (tap2_o),
    .tap3_o     (tap3_o),
    .tap4_o     (tap4_o),
    .dlev_o     (dlev_o)
);

// File: tb/dfe_adapt_top_tb_top.sv
`timescale 1ns/1ps
module dfe_adapt_top_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [7:0] samp = '0;
    logic              samp_vld = 1'b0;
    logic              adapt_en = 1'b0;
    logic              load = 1'b0;
    logic [4:0]        ld_t1 = '0;
    logic signed [4:0] ld_t2 = '0;
    logic signed [3:0] ld_t3 = '0;
    logic signed [3:0] ld_t4 = '0;
    logic [6:0]        ld_dl = '0;
    logic              dec, err_neg, vld;
    logic signed [8:0] eq;
    logic [4:0]        t1;
    logic signed [4:0] t2;
    logic signed [3:0] t3, t4;
    logic [6:0]        dl;

    always #5 clk = ~clk;

    dfe_adapt_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .samp_i(samp), .samp_vld_i(samp_vld),
        .adapt_en_i(adapt_en), .load_i(load), .ld_tap1_i(ld_t1), .ld_tap2_i(ld_t2),
        .ld_tap3_i(ld_t3), .ld_tap4_i(ld_t4), .ld_dlev_i(ld_dl),
        .dec_o(dec), .eq_o(eq), .err_neg_o(err_neg), .vld_o(vld),
        .tap1_o(t1), .tap2_o(t2), .tap3_o(t3), .tap4_o(t4), .dlev_o(dl)
    );

    typedef struct {
        int    dec;
        int    eq;
        int    en;
        int    w[4];
        int    lv;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    int w[4] = '{0, 0, 0, 0};
    int hn[4] = '{0, 0, 0, 0};
    int lv = 32;
    int hi[4] = '{31, 15, 7, 7};
    int lo[4] = '{0, -15, -7, -7};
    int ldw[4] = '{0, 0, 0, 0};
    int ldl = 0;

    function automatic int clampi(int v, int l, int h);
        return (v < l) ? l : ((v > h) ? h : v);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_load();
        for (int i = 0; i < 4; i++) w[i] = clampi(ldw[i], lo[i], hi[i]);
        lv = clampi(ldl, 0, 127);
    endtask

    task automatic drive_ld();
        ld_t1 = 5'(ldw[0]); ld_t2 = 5'(ldw[1]); ld_t3 = 4'(ldw[2]); ld_t4 = 4'(ldw[3]);
        ld_dl = 7'(ldl);
    endtask

    // Driver: presents one sample and pushes the model's prediction.
    task automatic send(int x, bit ad, bit ld, string tag);
        exp_t e;
        int isi, z, d, er;
        @(negedge clk);
        samp = 8'(x); samp_vld = 1'b1; adapt_en = ad; load = ld; drive_ld();
        isi = 0;
        for (int i = 0; i < 4; i++) isi += hn[i] ? -w[i] : w[i];
        z  = x - isi;
        d  = (z >= 0) ? 1 : 0;
        er = z - (d ? lv : -lv);
        e.dec = d; e.eq = z; e.en = (er < 0) ? 1 : 0; e.tag = tag;
        if (ad) begin
            for (int i = 0; i < 4; i++)
                w[i] = clampi(w[i] + (((e.en != 0) == (hn[i] != 0)) ? 1 : -1), lo[i], hi[i]);
            lv = clampi(lv + (((e.en != 0) == (d == 0)) ? 1 : -1), 0, 127);
        end else if (ld) begin
            apply_load();
        end
        for (int i = 3; i > 0; i--) hn[i] = hn[i-1];
        hn[0] = d ? 0 : 1;
        e.w = w; e.lv = lv;
        q.push_back(e);
        @(posedge clk); #1;
        samp_vld = 1'b0; load = 1'b0;
    endtask

    task automatic idle(int n, bit ad, bit ld);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            samp_vld = 1'b0; adapt_en = ad; load = ld; drive_ld();
            if (ld && !ad) apply_load();
            @(posedge clk); #1;
            load = 1'b0;
        end
    endtask

    task automatic check_weights(string req);
        @(negedge clk);
        check(int'(t1) == w[0], req, "tap1", int'(t1), w[0]);
        check(int'(t2) == w[1], req, "tap2", int'(t2), w[1]);
        check(int'(t3) == w[2], req, "tap3", int'(t3), w[2]);
        check(int'(t4) == w[3], req, "tap4", int'(t4), w[3]);
        check(int'(dl) == lv, req, "level", int'(dl), lv);
    endtask

    // Monitor: compares each produced result with the queued prediction.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && vld) begin
                if (q.size() == 0) begin
                    check(1'b0, "R3", "unexpected vld_o", 1, 0);
                end else begin
                    exp_t e;
                    bit ok;
                    e = q.pop_front();
                    ok = (int'(dec) == e.dec) && (int'(eq) == e.eq) && (int'(err_neg) == e.en)
                         && (int'(t1) == e.w[0]) && (int'(t2) == e.w[1]) && (int'(t3) == e.w[2])
                         && (int'(t4) == e.w[3]) && (int'(dl) == e.lv);
                    check(ok, e.tag, "eq/dec/err", int'(eq), e.eq);
                    if (!ok) $display("     dec %0d/%0d err %0d/%0d taps %0d %0d %0d %0d / %0d %0d %0d %0d lvl %0d/%0d",
                        dec, e.dec, err_neg, e.en, t1, t2, t3, t4, e.w[0], e.w[1], e.w[2], e.w[3], dl, e.lv);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int h[5] = '{40, 20, 10, -5, 3};
        int a[5] = '{1, 1, 1, 1, 1};
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        @(negedge clk);
        check(vld == 0 && dec == 0 && eq == 0 && err_neg == 0, "R11", "outputs after reset", int'(eq), 0);
        check(t1 == 0 && t2 == 0 && t3 == 0 && t4 == 0, "R11", "taps after reset", int'(t2), 0);
        check(int'(dl) == 32, "R11", "level after reset", int'(dl), 32);

        // R1 R2 R3 R4 with zero taps, adaptation off; includes zero sample -> +1
        send(5, 0, 0, "R1 R4 plain sample");
        send(-3, 0, 0, "R2 negative slice");
        send(0, 0, 0, "R2 zero slices to +1");
        send(-128, 0, 0, "R1 extreme sample");
        send(33, 0, 0, "R4 residual sign");

        // R8 R7 preload with out-of-range values, no sample
        ldw = '{10, -16, 3, -8}; ldl = 40;
        idle(1, 0, 1);
        check_weights("R7 R8 clamped preload");
        check(int'(t3) == 3 && int'(t4) == -7 && int'(t2) == -15, "R7", "preload clamp tap4", int'(t4), -7);

        // R1 feedback subtraction with mixed history
        send(20, 0, 0, "R1 feedback sum");
        send(-20, 0, 0, "R1 feedback sum 2");
        send(7, 0, 0, "R1 feedback sum 3");
        send(-1, 0, 0, "R1 feedback sum 4");

        // R8 sample together with preload: old weights used, load lands
        ldw = '{4, 5, -2, 1}; ldl = 50;
        send(12, 0, 1, "R8 sample with load");
        check_weights("R8 load with sample");

        // R8 load ignored when adaptation high
        ldw = '{31, 15, 7, 7}; ldl = 100;
        send(30, 1, 1, "R8 load ignored while adapting");
        check_weights("R8 load ignored");
        check(int'(t1) != 31, "R8", "tap1 not preloaded", int'(t1), 5);

        // R9 idle cycles with adaptation high change nothing
        idle(4, 1, 0);
        check_weights("R9 idle hold");
        check(vld == 0, "R9", "vld low when idle", int'(vld), 0);

        // R7 saturation at upper limit of tap 2 while learning pushes up
        ldw = '{0, 15, 0, 0}; ldl = 40;
        idle(1, 0, 1);
        send(100, 0, 0, "R5 prime history");
        send(100, 0, 0, "R5 prime history 2");
        send(100, 0, 0, "R5 prime history 3");
        send(100, 0, 0, "R5 prime history 4");
        send(100, 1, 0, "R7 tap2 at upper limit");
        check(int'(t2) == 15, "R7", "tap2 held at 15", int'(t2), 15);
        check(int'(t1) == 1, "R5", "tap1 stepped up", int'(t1), 1);

        // R7 tap1 floor at zero while learning pushes down
        ldw = '{0, 0, 0, 0}; ldl = 40;
        idle(1, 0, 1);
        send(1, 1, 0, "R7 tap1 floor");
        check(int'(t1) == 0, "R7", "tap1 held at 0", int'(t1), 0);
        check(int'(t2) == -1, "R5", "tap2 stepped down", int'(t2), -1);
        check(int'(dl) == 39, "R6", "level stepped down", int'(dl), 39);

        // R10 convergence on a known channel
        ldw = '{0, 0, 0, 0}; ldl = 20;
        idle(1, 0, 1);
        for (int n = 0; n < 3000; n++) begin
            int x;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            for (int i = 4; i > 0; i--) a[i] = a[i-1];
            a[0] = lfsr[0] ? 1 : -1;
            x = 0;
            for (int i = 0; i < 5; i++) x += h[i] * a[i];
            send(x, 1, 0, "R5 R6 adaptive run");
        end
        @(negedge clk);
        check(int'(t1) >= 18 && int'(t1) <= 22, "R10", "tap1 converged", int'(t1), 20);
        check(int'(t2) >= 8 && int'(t2) <= 12, "R10", "tap2 converged", int'(t2), 10);
        check(int'(t3) >= -7 && int'(t3) <= -3, "R10", "tap3 converged", int'(t3), -5);
        check(int'(t4) >= 1 && int'(t4) <= 5, "R10", "tap4 converged", int'(t4), 3);
        check(int'(dl) >= 38 && int'(dl) <= 42, "R10", "level converged", int'(dl), 40);

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R3", "pending results", q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule